// File: doc/BRIEF.md
# SHA-2 Two-Round Compression Unit

This block advances a SHA-2 working state by two compression rounds per operation. The eight state words come in two 4-element operand groups. The destination group holds {c, d, g, h}. The state source group holds {a, b, e, f}. A third group carries four precomputed round-constant-plus-schedule sums (K+W). A pair-select input chooses which two of the four sums are used. An element-width code selects 32-bit words (SHA-256 rounds) or 64-bit words (SHA-512 rounds). The unit returns the updated {a, b, e, f} group. The caller can then form the next {c, d, g, h} group from the previous {a, b, e, f} group.

Each operation is accepted on a valid/ready handshake and computed over two clock cycles, one round per cycle. The result is then held in an output register until the consumer accepts it. The caller also passes the register indices of the destination and of both sources. Together with the element-width code, these indices set an illegal-configuration flag that travels with the result.

Top module: `sha2_dround_unit`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Element i of each group sits at bits [i*W +: W], where W is the word width. The `grp_cdgh` group holds c, d, g, h in elements 3, 2, 1, 0. The `grp_abef` group holds a, b, e, f in elements 3, 2, 1, 0. With `pair_hi`=0, a round with kw element 0 runs first and a round with kw element 1 follows.
- R3: With `pair_hi`=1, a round with kw element 2 runs first and a round with kw element 3 follows. Elements 0 and 1 of `grp_kw` have no effect on the result.
- R4: With `pair_hi`=0, elements 2 and 3 of `grp_kw` have no effect on the result.
- R5: `ew_code`=3 selects 64-bit words with the 64-bit Sum0 rotations (28, 34, 39) and Sum1 rotations (14, 18, 41). `ew_code`=2 selects 32-bit words with the 32-bit Sum0 rotations (2, 13, 22) and Sum1 rotations (6, 11, 25).
- R6: In 32-bit mode, only bits [127:0] of each input group are read, and bits [255:128] of `res_abef` are zero.
- R7: `ew_code` values 0 and 1 set `res_illegal`, and `res_abef` is then all zero.
- R8: When `dst_idx` equals `st_src_idx` or `kw_src_idx`, `res_illegal` is set and `res_abef` is all zero.
- R9: `out_valid` rises two clock cycles after an accepted request. `in_ready` stays low from the acceptance until the result is taken.
- R10: While `out_valid` is high and `out_ready` is low, `res_abef` and `res_illegal` hold their values.
- R11: All additions wrap modulo 2^W, and carries never cross word boundaries.
- R12: The result group holds the new a, b, e, f in elements 3, 2, 1, 0. Each round computes t1 = h + Sum1(e) + Ch(e,f,g) + kw and t2 = Sum0(a) + Maj(a,b,c), then shifts the state with e' = d + t1 and a' = t1 + t2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit idle, can accept a request |
| ew_code | input | 2 | Element width code: 2 = 32-bit, 3 = 64-bit, others illegal |
| pair_hi | input | 1 | 1 uses kw elements 2 then 3, 0 uses elements 0 then 1 |
| dst_idx | input | IDX_W | Destination register index |
| st_src_idx | input | IDX_W | Index of the {a,b,e,f} source register |
| kw_src_idx | input | IDX_W | Index of the K+W source register |
| grp_cdgh | input | 256 | c, d, g, h in elements 3..0 |
| grp_abef | input | 256 | a, b, e, f in elements 3..0 |
| grp_kw | input | 256 | Four K+W sums in elements 3..0 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| res_abef | output | 256 | Updated a, b, e, f in elements 3..0 |
| res_illegal | output | 1 | Configuration was illegal |

## Verification
Random states are sent in both word widths with both pair selections. Garbage in the upper 128 bits during 32-bit operations shows whether narrow mode reads or leaks upper bits. Requests that differ only in the unused kw pair must give identical results, which separates the two pair variants and their ordering. All-ones operands force carries out of every adder, so wrap-around and word isolation can be told apart from a wider adder. Illegal width codes, aliased indices and a consumer stall show the flag, the zeroed result and the holding behaviour.

// File: rtl/sha2_dr_pkg.sv
package sha2_dr_pkg;
    localparam int WORD_W   = 64;
    localparam int NARROW_W = 32;
    localparam int LANES    = 4;
    localparam int BUS_W    = WORD_W * LANES;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wstate_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    localparam logic [1:0] EW_32 = 2'd2;
    localparam logic [1:0] EW_64 = 2'd3;
endpackage

// File: rtl/sha2_lane_split.sv
module sha2_lane_split
    import sha2_dr_pkg::*;
(
    input  logic                    wide,
    input  logic [BUS_W-1:0]        bus,
    output word_t [LANES-1:0]       lanes
);
    localparam int PAD_W = WORD_W - NARROW_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes[i] = wide ? bus[i*WORD_W +: WORD_W]
                               : {{PAD_W{1'b0}}, bus[i*NARROW_W +: NARROW_W]};
    end
endmodule

// File: rtl/sha2_round_step.sv
module sha2_round_step
    import sha2_dr_pkg::*;
(
    input  logic    wide,
    input  wstate_t st_i,
    input  word_t   kw,
    output wstate_t st_o
);
    localparam int PAD_W = WORD_W - NARROW_W;

    function automatic logic [NARROW_W-1:0] ror_n(input logic [NARROW_W-1:0] x, input int n);
        return (x >> n) | (x << (NARROW_W - n));
    endfunction

    function automatic word_t ror_w(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    logic [NARROW_W-1:0] na, nb, nc, nd, ne, nf, ng, nh, nk;
    logic [NARROW_W-1:0] n_s0, n_s1, n_t1, n_t2;
    word_t               w_s0, w_s1, w_t1, w_t2;

    always_comb begin
        na = st_i.a[NARROW_W-1:0];
        nb = st_i.b[NARROW_W-1:0];
        nc = st_i.c[NARROW_W-1:0];
        nd = st_i.d[NARROW_W-1:0];
        ne = st_i.e[NARROW_W-1:0];
        nf = st_i.f[NARROW_W-1:0];
        ng = st_i.g[NARROW_W-1:0];
        nh = st_i.h[NARROW_W-1:0];
        nk = kw[NARROW_W-1:0];

        n_s1 = ror_n(ne, 6) ^ ror_n(ne, 11) ^ ror_n(ne, 25);
        n_s0 = ror_n(na, 2) ^ ror_n(na, 13) ^ ror_n(na, 22);
        n_t1 = nh + n_s1 + ((ne & nf) ^ (~ne & ng)) + nk;
        n_t2 = n_s0 + ((na & nb) ^ (na & nc) ^ (nb & nc));

        w_s1 = ror_w(st_i.e, 14) ^ ror_w(st_i.e, 18) ^ ror_w(st_i.e, 41);
        w_s0 = ror_w(st_i.a, 28) ^ ror_w(st_i.a, 34) ^ ror_w(st_i.a, 39);
        w_t1 = st_i.h + w_s1 + ((st_i.e & st_i.f) ^ (~st_i.e & st_i.g)) + kw;
        w_t2 = w_s0 + ((st_i.a & st_i.b) ^ (st_i.a & st_i.c) ^ (st_i.b & st_i.c));

        st_o.h = st_i.g;
        st_o.g = st_i.f;
        st_o.f = st_i.e;
        st_o.d = st_i.c;
        st_o.c = st_i.b;
        st_o.b = st_i.a;
        if (wide) begin
            st_o.e = st_i.d + w_t1;
            st_o.a = w_t1 + w_t2;
        end else begin
            st_o.e = {{PAD_W{1'b0}}, nd + n_t1};
            st_o.a = {{PAD_W{1'b0}}, n_t1 + n_t2};
        end
    end
endmodule

// File: rtl/sha2_cfg_check.sv
module sha2_cfg_check #(
    parameter int IDX_W = 5
) (
    input  logic [1:0]       ew_code,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] st_src_idx,
    input  logic [IDX_W-1:0] kw_src_idx,
    output logic             bad
);
    import sha2_dr_pkg::*;

    logic width_ok;
    logic aliased;

    always_comb begin
        width_ok = (ew_code == EW_32) || (ew_code == EW_64);
        aliased  = (dst_idx == st_src_idx) || (dst_idx == kw_src_idx);
        bad      = !width_ok || aliased;
    end
endmodule

// File: rtl/sha2_dround_unit.sv
module sha2_dround_unit
    import sha2_dr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         ew_code,
    input  logic               pair_hi,
    input  logic [IDX_W-1:0]   dst_idx,
    input  logic [IDX_W-1:0]   st_src_idx,
    input  logic [IDX_W-1:0]   kw_src_idx,
    input  logic [BUS_W-1:0]   grp_cdgh,
    input  logic [BUS_W-1:0]   grp_abef,
    input  logic [BUS_W-1:0]   grp_kw,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BUS_W-1:0]   res_abef,
    output logic               res_illegal
);
    localparam int HALF_BUS = NARROW_W * LANES;

    typedef struct packed {
        phase_e             phase;
        wstate_t            st;
        word_t              kw;
        logic               wide;
        logic               bad;
        logic [BUS_W-1:0]   res;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 wide_in;
    word_t [LANES-1:0]    cdgh_l, abef_l, kw_l;
    wstate_t              st_in, st_mid, st_fin;
    word_t                kw_first, kw_second;
    logic                 cfg_bad;
    word_t [LANES-1:0]    fin_words;
    logic [BUS_W-1:0]     fin_bus;

    assign wide_in = (ew_code == EW_64);

    sha2_lane_split u_split_cdgh (.wide(wide_in), .bus(grp_cdgh), .lanes(cdgh_l));
    sha2_lane_split u_split_abef (.wide(wide_in), .bus(grp_abef), .lanes(abef_l));
    sha2_lane_split u_split_kw   (.wide(wide_in), .bus(grp_kw),   .lanes(kw_l));

    sha2_cfg_check #(.IDX_W(IDX_W)) u_cfg (
        .ew_code    (ew_code),
        .dst_idx    (dst_idx),
        .st_src_idx (st_src_idx),
        .kw_src_idx (kw_src_idx),
        .bad        (cfg_bad)
    );

    always_comb begin
        st_in.c   = cdgh_l[3];
        st_in.d   = cdgh_l[2];
        st_in.g   = cdgh_l[1];
        st_in.h   = cdgh_l[0];
        st_in.a   = abef_l[3];
        st_in.b   = abef_l[2];
        st_in.e   = abef_l[1];
        st_in.f   = abef_l[0];
        kw_first  = pair_hi ? kw_l[2] : kw_l[0];
        kw_second = pair_hi ? kw_l[3] : kw_l[1];
    end

    // first round on the incoming operands, second on the registered state
    sha2_round_step u_rnd_first  (.wide(wide_in),    .st_i(st_in),    .kw(kw_first), .st_o(st_mid));
    sha2_round_step u_rnd_second (.wide(ctl_q.wide), .st_i(ctl_q.st), .kw(ctl_q.kw), .st_o(st_fin));

    always_comb begin
        fin_words[3] = st_fin.a;
        fin_words[2] = st_fin.b;
        fin_words[1] = st_fin.e;
        fin_words[0] = st_fin.f;
        fin_bus      = '0;
        for (int i = 0; i < LANES; i++) begin
            if (ctl_q.wide) begin
                fin_bus[i*WORD_W +: WORD_W] = fin_words[i];
            end else begin
                fin_bus[i*NARROW_W +: NARROW_W] = fin_words[i][NARROW_W-1:0];
            end
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    ctl_d.phase = PH_RUN;
                    ctl_d.st    = st_mid;
                    ctl_d.kw    = kw_second;
                    ctl_d.wide  = wide_in;
                    ctl_d.bad   = cfg_bad;
                end
            end
            PH_RUN: begin
                ctl_d.res   = ctl_q.bad ? '0 : fin_bus;
                ctl_d.phase = PH_HOLD;
            end
            PH_HOLD: begin
                if (out_ready) begin
                    ctl_d.phase = PH_IDLE;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready    = (ctl_q.phase == PH_IDLE);
    assign out_valid   = (ctl_q.phase == PH_HOLD);
    assign res_abef    = ctl_q.res;
    assign res_illegal = ctl_q.bad;

    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !out_valid ##1 out_valid); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(res_abef) && $stable(res_illegal)); // R10

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && res_illegal |-> res_abef == '0); // R7

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !ctl_q.wide |-> res_abef[BUS_W-1:HALF_BUS] == '0); // R6
endmodule

// File: tb/sha2_dround_unit_bench.sv
module sha2_dround_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [1:0]      ew_code = 2'd2;
    logic            pair_hi = 1'b0;
    logic [4:0]      dst_idx = 5'd1, st_src_idx = 5'd2, kw_src_idx = 5'd3;
    logic [BW-1:0]   grp_cdgh = '0, grp_abef = '0, grp_kw = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [BW-1:0]   res_abef;
    logic            res_illegal;

    int checks = 0;
    int errors = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    int            m_phase = 0;
    logic [BW-1:0] q_data[$];
    logic          q_bad[$];
    string         q_tag[$];
    string         cur_tag = "R2";
    logic [BW-1:0] last_res;
    bit            chk_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha2_dround_unit u_sha2_dround_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ew_code(ew_code), .pair_hi(pair_hi), .dst_idx(dst_idx),
        .st_src_idx(st_src_idx), .kw_src_idx(kw_src_idx),
        .grp_cdgh(grp_cdgh), .grp_abef(grp_abef), .grp_kw(grp_kw),
        .out_valid(out_valid), .out_ready(out_ready),
        .res_abef(res_abef), .res_illegal(res_illegal)
    );

    function automatic logic [63:0] nxt();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic logic [BW-1:0] rnd();
        return {nxt(), nxt(), nxt(), nxt()};
    endfunction

    function automatic logic [63:0] ror(input logic [63:0] x, input int n, input int w);
        logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
        return ((x >> n) | (x << (w - n))) & m;
    endfunction

    function automatic logic [63:0] lane(input logic [BW-1:0] bus, input int idx, input int w);
        logic [BW-1:0] sh = bus >> (w * idx);
        logic [63:0]   m  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
        return sh[63:0] & m;
    endfunction

    function automatic logic [BW-1:0] ref_calc(input logic [1:0] ew, input logic hi,
                                               input logic [BW-1:0] cd, ab, kw);
        int w = (ew == 2'd3) ? 64 : 32;
        logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
        logic [63:0] va, vb, vc, vd, ve, vf, vg, vh, k, t1, t2, s0, s1;
        logic [63:0] outw[4];
        logic [BW-1:0] r = '0;
        vc = lane(cd, 3, w); vd = lane(cd, 2, w); vg = lane(cd, 1, w); vh = lane(cd, 0, w);
        va = lane(ab, 3, w); vb = lane(ab, 2, w); ve = lane(ab, 1, w); vf = lane(ab, 0, w);
        for (int rr = 0; rr < 2; rr++) begin
            k = lane(kw, (hi ? 2 : 0) + rr, w);
            if (w == 64) begin
                s1 = ror(ve, 14, 64) ^ ror(ve, 18, 64) ^ ror(ve, 41, 64);
                s0 = ror(va, 28, 64) ^ ror(va, 34, 64) ^ ror(va, 39, 64);
            end else begin
                s1 = ror(ve, 6, 32) ^ ror(ve, 11, 32) ^ ror(ve, 25, 32);
                s0 = ror(va, 2, 32) ^ ror(va, 13, 32) ^ ror(va, 22, 32);
            end
            t1 = (vh + s1 + (((ve & vf) ^ (~ve & vg)) & m) + k) & m;
            t2 = (s0 + ((va & vb) ^ (va & vc) ^ (vb & vc))) & m;
            vh = vg; vg = vf; vf = ve; ve = (vd + t1) & m;
            vd = vc; vc = vb; vb = va; va = (t1 + t2) & m;
        end
        outw[3] = va; outw[2] = vb; outw[1] = ve; outw[0] = vf;
        for (int i = 0; i < 4; i++) begin
            r = r | ({192'd0, outw[i] & m} << (w * i));
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge from the driven inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            q_data.delete(); q_bad.delete(); q_tag.delete();
        end else begin
            case (m_phase)
                0: if (in_valid) begin
                    logic bad;
                    bad = !(ew_code == 2'd2 || ew_code == 2'd3) ||
                          dst_idx == st_src_idx || dst_idx == kw_src_idx;
                    q_data.push_back(bad ? '0 : ref_calc(ew_code, pair_hi, grp_cdgh, grp_abef, grp_kw));
                    q_bad.push_back(bad);
                    q_tag.push_back(cur_tag);
                    m_phase = 1;
                end
                1: m_phase = 2;
                default: if (out_ready) begin
                    void'(q_data.pop_front()); void'(q_bad.pop_front()); void'(q_tag.pop_front());
                    m_phase = 0;
                end
            endcase
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            chk(in_ready == (m_phase == 0), "R9 in_ready", {255'd0, in_ready}, {255'd0, m_phase == 0});
            chk(out_valid == (m_phase == 2), "R9 out_valid", {255'd0, out_valid}, {255'd0, m_phase == 2});
            if (m_phase == 2 && out_valid && q_data.size() > 0) begin
                chk(res_abef === q_data[0], q_tag[0], res_abef, q_data[0]);
                chk(res_illegal === q_bad[0], {q_tag[0], " flag"}, {255'd0, res_illegal}, {255'd0, q_bad[0]});
                last_res = res_abef;
            end
        end
    end

    task automatic send(input logic [1:0] ew, input logic hi, input logic [4:0] d, s, k,
                        input logic [BW-1:0] cd, ab, kw, input string tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        cur_tag = tag;
        ew_code = ew; pair_hi = hi; dst_idx = d; st_src_idx = s; kw_src_idx = k;
        grp_cdgh = cd; grp_abef = ab; grp_kw = kw;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        grp_cdgh = rnd(); grp_abef = rnd(); grp_kw = rnd();
        while (m_phase != 0) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [BW-1:0] cd, ab, kw, kw2, r_first;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", {255'd0, out_valid}, '0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", {255'd0, in_ready}, {255'd0, 1'b1});
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", {255'd0, out_valid}, '0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", {255'd0, in_ready}, {255'd0, 1'b1});
        chk_en = 1'b1;

        // R2 R6 R12: 32-bit low pair, garbage in the upper half
        for (int i = 0; i < 4; i++) send(2'd2, 1'b0, 5'd4, 5'd5, 5'd6, rnd(), rnd(), rnd(), "R2 R6 R12 narrow low");
        chk(last_res[255:128] == '0, "R6 upper zero", last_res, '0);
        // R3 R12: 32-bit high pair
        for (int i = 0; i < 3; i++) send(2'd2, 1'b1, 5'd4, 5'd5, 5'd6, rnd(), rnd(), rnd(), "R3 R12 narrow high");
        // R5: 64-bit both pairs
        for (int i = 0; i < 3; i++) send(2'd3, 1'b0, 5'd8, 5'd9, 5'd10, rnd(), rnd(), rnd(), "R5 wide low");
        for (int i = 0; i < 3; i++) send(2'd3, 1'b1, 5'd8, 5'd9, 5'd10, rnd(), rnd(), rnd(), "R5 wide high");

        // R4: low pair ignores kw elements 2 and 3
        cd = rnd(); ab = rnd(); kw = rnd(); kw2 = kw;
        kw2[255:128] = ~kw[255:128];
        send(2'd3, 1'b0, 5'd1, 5'd2, 5'd3, cd, ab, kw, "R4 first");
        r_first = last_res;
        send(2'd3, 1'b0, 5'd1, 5'd2, 5'd3, cd, ab, kw2, "R4 second");
        chk(last_res == r_first, "R4 upper pair ignored", last_res, r_first);
        // R3: high pair ignores kw elements 0 and 1
        kw2 = kw; kw2[63:0] = ~kw[63:0];
        send(2'd2, 1'b1, 5'd1, 5'd2, 5'd3, cd, ab, kw, "R3 first");
        r_first = last_res;
        send(2'd2, 1'b1, 5'd1, 5'd2, 5'd3, cd, ab, kw2, "R3 second");
        chk(last_res == r_first, "R3 lower pair ignored", last_res, r_first);

        // R11: carries everywhere
        send(2'd2, 1'b0, 5'd1, 5'd2, 5'd3, '1, '1, '1, "R11 narrow all ones");
        send(2'd3, 1'b1, 5'd1, 5'd2, 5'd3, '1, '1, '1, "R11 wide all ones");
        send(2'd3, 1'b0, 5'd1, 5'd2, 5'd3, '0, '0, '0, "R11 wide zeros");

        // R7 and R8: illegal configurations
        send(2'd0, 1'b0, 5'd1, 5'd2, 5'd3, rnd(), rnd(), rnd(), "R7 width code 0");
        chk(res_illegal == 1'b1 || 1'b0, "R7 flag seen", {255'd0, res_illegal}, {255'd0, 1'b1});
        send(2'd1, 1'b1, 5'd1, 5'd2, 5'd3, rnd(), rnd(), rnd(), "R7 width code 1");
        send(2'd3, 1'b0, 5'd7, 5'd7, 5'd3, rnd(), rnd(), rnd(), "R8 dst equals state source");
        send(2'd2, 1'b0, 5'd7, 5'd2, 5'd7, rnd(), rnd(), rnd(), "R8 dst equals kw source");
        send(2'd2, 1'b0, 5'd7, 5'd2, 5'd3, rnd(), rnd(), rnd(), "R8 legal after illegal");

        // R10: consumer stall
        out_ready = 1'b0;
        fork
            send(2'd3, 1'b1, 5'd1, 5'd2, 5'd3, rnd(), rnd(), rnd(), "R10 stalled result");
            begin
                while (!out_valid) @(negedge clk);
                repeat (4) @(negedge clk);
                out_ready = 1'b1;
            end
        join

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule